// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and flag stage of an 8-bit accumulator datapath. Each cycle it takes an operation selector, the accumulator value and one operand byte, and it produces a combinational result that the surrounding datapath writes back to the accumulator. It supports four operations: add, add with the stored carry, increment and bitwise AND. Only the two add operations touch the arithmetic flags.

The block holds the status byte in a register. Seven of its bits are stored: carry, half-carry, a user flag, two bank-select bits, overflow and a spare general flag. The lowest bit is the accumulator parity. It is not stored and always follows the accumulator input. Software can replace the seven stored bits through a write strobe. From the two bank-select bits the block derives the base address of the active eight-register bank.

Top module: `alu8_flag_unit`

## Requirements
- R1: After a cycle with `rst_n` low, the seven stored status bits read 0 and `bank_base` is 0x00.
- R2: With `op_sel`=2'b00 (add), `result` equals (`acc_in` + `opnd_in`) mod 256 in the same cycle.
- R3: With `op_sel`=2'b01 (add with carry), `result` equals (`acc_in` + `opnd_in` + stored carry) mod 256, where the stored carry is `psw_out[7]`.
- R4: After an accepted add or add-with-carry, `psw_out[7]` (carry) holds the carry out of bit 7 from the next cycle on.
- R5: After an accepted add or add-with-carry, `psw_out[6]` (half-carry) holds the carry out of bit 3 from the next cycle on.
- R6: After an accepted add or add-with-carry, `psw_out[2]` (overflow) is 1 exactly when both addends have the same bit 7 and the result's bit 7 differs from it.
- R7: With `op_sel`=2'b10 (increment), `result` equals (`acc_in` + 1) mod 256, so 0xFF gives 0x00, and bits 7, 6 and 2 of `psw_out` stay unchanged.
- R8: With `op_sel`=2'b11 (AND), `result` equals `acc_in` & `opnd_in`, and bits 7, 6 and 2 of `psw_out` stay unchanged.
- R9: `psw_out[0]` equals 1 exactly when `acc_in` holds an odd number of ones, in the same cycle, whatever the stored bits or a write.
- R10: A cycle with `psw_wr` high loads `psw_wdata[7:1]` into `psw_out[7:1]` on the next cycle, and takes priority over a flag update from an operation in that same cycle.
- R11: `bank_base` equals `psw_out[4:3]` times 8: 2'b00 gives 0x00, 2'b01 gives 0x08, 2'b10 gives 0x10 and 2'b11 gives 0x18.
- R12: Operations never change `psw_out[5]`, `psw_out[4:3]` or `psw_out[1]`. A cycle with neither `op_valid` nor `psw_wr` leaves `psw_out[7:1]` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation accepted this cycle; flags update on the edge |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 increment, 11 AND |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand byte |
| psw_wr | input | 1 | Direct write of the stored status bits |
| psw_wdata | input | 7 | New values for status bits 7 down to 1 |
| result | output | 8 | Combinational operation result |
| psw_out | output | 8 | Status byte: bit 7 carry, bit 6 half-carry, bit 5 user flag, bits 4:3 bank select, bit 2 overflow, bit 1 general flag, bit 0 parity |
| bank_base | output | 8 | Base address of the selected register bank |

## Verification
A wrong stored carry shows up in two places. It appears on `psw_out[7]` one cycle after the operation that set it. In the same cycle that an add-with-carry consumes it, it also shifts `result` by one. Half-carry and overflow errors are visible only on `psw_out` one cycle after an add, so the directed patterns are chosen so that each flag toggles on its own. A parity error shows on `psw_out[0]` in the same cycle that the accumulator changes. A bank-select bit that is stored wrongly moves `bank_base` one cycle after the write. Both the add path and the write path are exercised, and the stored bits are then read back on the ports.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and status-byte bit positions.
// Assumes an 8-bit status byte whose layout is fixed by the datapath.
package alu8_pkg;
    localparam int PSW_W  = 8;
    localparam int CY_BIT = 7;
    localparam int AC_BIT = 6;
    localparam int UF_BIT = 5;
    localparam int RS_HI  = 4;
    localparam int RS_LO  = 3;
    localparam int OV_BIT = 2;
    localparam int GF_BIT = 1;
    localparam int P_BIT  = 0;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_ADDC = 2'b01,
        OP_INC  = 2'b10,
        OP_AND  = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu8_adder.sv
// Ripple-carry adder that exposes the full carry chain.
// Provides the sum, the carry out of the top bit, the carry out of the
// lower nibble (half-carry) and the signed overflow. Assumes HALF_W < W.
module alu8_adder #(
    parameter int W      = 8,
    parameter int HALF_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         c_half,
    output logic         ovf
);
    logic [W:0] carry;

    assign carry[0] = cin;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign c_out  = carry[W];
    assign c_half = carry[HALF_W];
    assign ovf    = carry[W] ^ carry[W-1];
endmodule

// File: rtl/alu8_parity.sv
// Odd-parity generator: the output is 1 when the input has an odd number of ones.
// Purely combinational. Built as an XOR chain so that it works for any width.
module alu8_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic         odd
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    // Fold each bit into the running XOR.
    for (genvar i = 0; i < W; i++) begin : g_x
        assign chain[i+1] = chain[i] ^ din[i];
    end

    assign odd = chain[W];
endmodule

// File: rtl/alu8_psw_reg.sv
// Stored status bits 7 down to 1 (the parity bit is live logic elsewhere).
// A direct write wins over an arithmetic update in the same cycle. Only the
// carry, half-carry and overflow bits take arithmetic updates.
module alu8_psw_reg
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PSW_W-1:1] wr_data,
    input  logic             arith_upd,
    input  logic             cy_new,
    input  logic             ac_new,
    input  logic             ov_new,
    output logic [PSW_W-1:1] state
);
    // Holds, loads or updates the stored status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (wr_en) begin
            state <= wr_data;
        end else if (arith_upd) begin
            state[CY_BIT] <= cy_new;
            state[AC_BIT] <= ac_new;
            state[OV_BIT] <= ov_new;
        end
    end
endmodule

// File: rtl/alu8_bank_map.sv
// Maps the two bank-select bits to the base address of a register bank.
// Assumes BANK_REGS is a power of two and that the address fits ADDR_W.
module alu8_bank_map #(
    parameter int BANK_REGS = 8,
    parameter int ADDR_W    = 8
) (
    input  logic [1:0]        rs,
    output logic [ADDR_W-1:0] base
);
    localparam int SHIFT = $clog2(BANK_REGS);

    // Scale the bank index by the bank size.
    always_comb begin
        base = ADDR_W'(rs) << SHIFT;
    end
endmodule

// File: rtl/alu8_flag_unit.sv
// Top level: arithmetic and flag unit for an 8-bit accumulator datapath.
// The result is combinational. Status bits 7..1 are registered, bit 0 is
// the live accumulator parity and bank_base follows the stored select bits.
// Assumes the caller writes result back into the accumulator.
module alu8_flag_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HALF_W    = 4,
    parameter int BANK_REGS = 8,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              psw_wr,
    input  logic [PSW_W-1:1]  psw_wdata,
    output logic [DATA_W-1:0] result,
    output logic [PSW_W-1:0]  psw_out,
    output logic [ADDR_W-1:0] bank_base
);
    alu_op_e           op_e;
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cy;
    logic              add_ac;
    logic              add_ov;
    logic              is_arith;
    logic              par_odd;
    logic [PSW_W-1:1]  stored;

    assign op_e = alu_op_e'(op_sel);

    // Pick the adder's second input and carry-in for the selected operation.
    always_comb begin
        add_b    = opnd_in;
        add_cin  = 1'b0;
        is_arith = 1'b0;
        unique case (op_e)
            OP_ADD:  is_arith = 1'b1;
            OP_ADDC: begin
                is_arith = 1'b1;
                add_cin  = stored[CY_BIT];
            end
            OP_INC:  add_b = DATA_W'(1);
            OP_AND:  add_b = opnd_in;
        endcase
    end

    alu8_adder #(.W(DATA_W), .HALF_W(HALF_W)) adder_i (
        .a      (acc_in),
        .b      (add_b),
        .cin    (add_cin),
        .sum    (add_sum),
        .c_out  (add_cy),
        .c_half (add_ac),
        .ovf    (add_ov)
    );

    // Route the adder or the AND product to the result.
    always_comb begin
        result = (op_e == OP_AND) ? (acc_in & opnd_in) : add_sum;
    end

    alu8_psw_reg psw_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (psw_wr),
        .wr_data   (psw_wdata),
        .arith_upd (op_valid & is_arith),
        .cy_new    (add_cy),
        .ac_new    (add_ac),
        .ov_new    (add_ov),
        .state     (stored)
    );

    alu8_parity #(.W(DATA_W)) par_i (
        .din (acc_in),
        .odd (par_odd)
    );

    assign psw_out = {stored, par_odd};

    alu8_bank_map #(.BANK_REGS(BANK_REGS), .ADDR_W(ADDR_W)) bank_i (
        .rs   (stored[RS_HI:RS_LO]),
        .base (bank_base)
    );

    // Reference sums used only by the assertions below.
    logic [DATA_W:0] ref_add;
    logic [DATA_W:0] ref_addc;
    assign ref_add  = {1'b0, acc_in} + {1'b0, opnd_in};
    assign ref_addc = {1'b0, acc_in} + {1'b0, opnd_in} + (DATA_W+1)'(psw_out[CY_BIT]);

    // R4
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !psw_wr && op_sel == 2'b00) |=> psw_out[CY_BIT] == $past(ref_add[DATA_W]));

    // R3
    addc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01) |-> result == ref_addc[DATA_W-1:0]);

    // R7
    inc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !psw_wr && op_sel == 2'b10) |=>
        (psw_out[CY_BIT] == $past(psw_out[CY_BIT]) && psw_out[AC_BIT] == $past(psw_out[AC_BIT])
         && psw_out[OV_BIT] == $past(psw_out[OV_BIT])));

    // R8
    and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !psw_wr && op_sel == 2'b11) |=>
        (psw_out[CY_BIT] == $past(psw_out[CY_BIT]) && psw_out[AC_BIT] == $past(psw_out[AC_BIT])
         && psw_out[OV_BIT] == $past(psw_out[OV_BIT])));

    // R9
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_out[P_BIT] == $countones(acc_in) % 2);

    // R10
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_wr |=> psw_out[PSW_W-1:1] == $past(psw_wdata));

    // R11
    bank_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_base == ADDR_W'(psw_out[RS_HI:RS_LO]) * ADDR_W'(BANK_REGS));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !psw_wr) |=> $stable(psw_out[PSW_W-1:1]));
endmodule

// File: tb/alu8_flag_unit_tb_top.sv
// Directed bench: one task per scenario, each checking its own results
// against a model of the stored status bits kept in the bench.
module alu8_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [1:0] op_sel;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic       psw_wr;
    logic [7:1] psw_wdata;
    logic [7:0] result;
    logic [7:0] psw_out;
    logic [7:0] bank_base;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:1] m_psw;  // model of stored bits: 7 CY, 6 AC, 5 F, 4:3 RS, 2 OV, 1 GF

    always #4 clk = ~clk;  // 125 MHz

    alu8_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
        .result(result), .psw_out(psw_out), .bank_base(bank_base)
    );

    function automatic logic par_of(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return logic'(n % 2);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Runs one accepted operation: checks the result, then the status after the edge.
    task automatic do_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                         input string req_res, input string req_flg);
        int cin;
        int s;
        int e_res;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; acc_in = a; opnd_in = b; psw_wr = 1'b0;
        #1;
        cin = (op == 2'b01) ? int'(m_psw[7]) : 0;
        case (op)
            2'b00, 2'b01: begin
                s = int'(a) + int'(b) + cin;
                e_res = s % 256;
                m_psw[7] = (s > 255);
                m_psw[6] = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
                m_psw[2] = (a[7] == b[7]) && (e_res[7] != a[7]);
            end
            2'b10: e_res = (int'(a) + 1) % 256;
            default: e_res = int'(a & b);
        endcase
        chk(req_res, int'(result), e_res);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk(req_flg, int'(psw_out), int'({m_psw, par_of(a)}));
    endtask

    task automatic write_psw(input logic [7:0] v, input logic with_op);
        @(negedge clk);
        psw_wr = 1'b1; psw_wdata = v[7:1];
        op_valid = with_op; op_sel = 2'b00; acc_in = 8'hFF; opnd_in = 8'hFF;
        @(negedge clk);
        psw_wr = 1'b0; op_valid = 1'b0;
        m_psw = v[7:1];
        #1;
        chk("R10 write", int'(psw_out), int'({v[7:1], par_of(acc_in)}));
    endtask

    task automatic test_reset();
        @(negedge clk);
        acc_in = 8'h00;
        #1;
        chk("R1 reset psw", int'(psw_out), 0);
        chk("R1 reset bank", int'(bank_base), 0);
    endtask

    task automatic test_add();
        do_op(2'b00, 8'h12, 8'h34, "R2 add plain", "R4 R5 R6 flags none");
        do_op(2'b00, 8'h0F, 8'h01, "R2 add nibble", "R5 half carry");
        do_op(2'b00, 8'h80, 8'h80, "R2 add wrap", "R4 R6 carry and overflow");
        do_op(2'b00, 8'h7F, 8'h01, "R2 add signed", "R6 overflow positive");
        do_op(2'b00, 8'hF0, 8'h20, "R2 add carry", "R4 carry no overflow");
    endtask

    task automatic test_addc();
        do_op(2'b00, 8'hFF, 8'h01, "R2 add set carry", "R4 carry set");
        do_op(2'b01, 8'h10, 8'h20, "R3 addc with carry", "R4 R5 addc flags");
        do_op(2'b01, 8'h10, 8'h20, "R3 addc no carry", "R4 addc clear");
        do_op(2'b00, 8'hFF, 8'hFF, "R2 add FF", "R4 R5 flags");
        do_op(2'b01, 8'hFF, 8'h00, "R3 addc rollover", "R4 R5 carry chain");
    endtask

    task automatic test_inc();
        do_op(2'b00, 8'h80, 8'h80, "R2 add set ov", "R6 ov set");
        do_op(2'b10, 8'hFF, 8'h55, "R7 inc wrap", "R7 flags held");
        do_op(2'b00, 8'h0F, 8'h01, "R2 add set ac", "R5 ac set");
        do_op(2'b10, 8'h7F, 8'h00, "R7 inc signed", "R7 flags held");
    endtask

    task automatic test_and();
        do_op(2'b00, 8'hFF, 8'hFF, "R2 add set cy", "R4 cy set");
        do_op(2'b11, 8'hF3, 8'h3C, "R8 and", "R8 flags held");
        do_op(2'b11, 8'hAA, 8'h55, "R8 and zero", "R8 flags held");
    endtask

    task automatic test_write();
        write_psw(8'hFE, 1'b0);
        write_psw(8'h00, 1'b1);  // write beats the add, which would set CY and AC
        write_psw(8'h26, 1'b1);
    endtask

    task automatic test_bank();
        for (int k = 0; k < 4; k++) begin
            write_psw(8'(k << 3), 1'b0);
            chk("R11 bank base", int'(bank_base), k * 8);
        end
    endtask

    task automatic test_parity();
        logic [7:0] pats [5] = '{8'h00, 8'h01, 8'h03, 8'h80, 8'hFE};
        write_psw(8'hAA, 1'b0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            acc_in = pats[k];
            #1;
            chk("R9 parity", int'(psw_out[0]), int'(par_of(pats[k])));
        end
    endtask

    task automatic test_idle();
        write_psw(8'h3A, 1'b0);  // F, RS=11, GF set
        do_op(2'b00, 8'h88, 8'h88, "R2 add", "R12 user bits kept");
        chk("R12 bank kept", int'(bank_base), 8'h18);
        @(negedge clk);
        op_valid = 1'b0; op_sel = 2'b00; acc_in = 8'hFF; opnd_in = 8'hFF;
        @(negedge clk);
        #1;
        chk("R12 idle hold", int'(psw_out[7:1]), int'(m_psw));
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_sel = 2'b00; acc_in = 8'h5A;
        opnd_in = 8'h00; psw_wr = 1'b1; psw_wdata = 7'h7F;
        m_psw = '0;
        repeat (3) @(negedge clk);
        psw_wr = 1'b0;
        rst_n = 1'b1;
        test_reset();
        test_add();
        test_addc();
        test_inc();
        test_and();
        test_write();
        test_bank();
        test_parity();
        test_idle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule